// File: doc/BRIEF.md
# Latency-Parameterized Target Pipeline Channel

This block joins one producer unit to one consumer unit of a cycle-level emulation model and carries data in a single direction. Seen in emulated (target) time, it is a plain delay line. A value handed over in target cycle t reaches the consumer in target cycle t+LAT, and nothing ever pushes back on the sender. On the physical host the delay line is a small FIFO. The producer's wrapper therefore pushes one word each time its unit completes a target cycle, and the consumer's wrapper pops one word each time its unit completes a target cycle. The two ends may finish their target cycles on unrelated host cycles.

After reset the FIFO already holds LAT zero words. The consumer can therefore run its first LAT target cycles before the producer has sent anything, and the k-th word the consumer reads equals the (k-LAT)-th word the producer sent. The storage has EXTRA spare slots beyond LAT, so the producer can run ahead by up to EXTRA target cycles. A full flag tells the producer's wrapper to hold off, and a ready flag tells the consumer's wrapper that the word for its next target cycle is present. A push into a full FIFO and a pop from an empty one are both dropped.

Top module: `tgt_pipe_chan`

## Requirements
- R1: In the first cycle after reset is released, `rdy_o` is 1, `full_o` is 0, and the first LAT words popped read as zero.
- R2: For any pattern of stalls on either side, the k-th popped word (counting from 0) equals the (k-LAT)-th accepted pushed word, for every k at or above LAT.
- R3: The FIFO holds LAT+EXTRA words. After reset, EXTRA accepted pushes with no pop raise `full_o`. The default EXTRA is 1.
- R4: `full_o` and `rdy_o` are registered. After each clock edge, `full_o` is 1 exactly when LAT+EXTRA words are held, and `rdy_o` is 1 exactly when at least one word is held. The two flags are never 1 and 0 respectively at the same time.
- R5: A push (`enq_i`=1) while `full_o` is 1 is dropped, even if a pop happens in the same cycle. The word it carries never appears at the consumer.
- R6: A pop (`deq_i`=1) while `rdy_o` is 0 is dropped. `rdy_o` stays 0, and the next accepted push becomes the next word popped.
- R7: When a push and a pop are both accepted in the same cycle, the word count does not change, and neither `full_o` nor `rdy_o` changes.
- R8: While `rdy_o` is 1, `deq_data_o` shows the word that the next pop consumes. With no pop, it holds steady, even while pushes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset; reloads LAT zero words |
| enq_i | input | 1 | Producer finished a target cycle: push `enq_data_i` |
| enq_data_i | input | WIDTH | Word sent by the producer |
| full_o | output | 1 | No room for another push |
| rdy_o | output | 1 | Word for the consumer's next target cycle is present |
| deq_i | input | 1 | Consumer finished a target cycle: pop the head word |
| deq_data_o | output | WIDTH | Head word, valid while `rdy_o` is 1 |

## Verification
The bound checker watches the flag behaviour on every cycle. It checks the flag values right after reset and that the flags never contradict each other. It checks that a dropped push or pop leaves the relevant flag unchanged, that a balanced push-and-pop leaves both flags steady, that a full FIFO is only ever reached through a push, and that the head word stays put between pops. Only the bench scenarios can show the end-to-end shift-by-LAT ordering, that a dropped word never resurfaces later, and that the preloaded zeros come out first. The bench shows these by running LAT of 1, 2 and 4 side by side under fixed and random stall patterns on both ends.

// File: rtl/chan_pkg.sv
package chan_pkg;

  // index width for a storage of n entries, never below one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // what the channel does on one host edge
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b10,
    OP_POP  = 2'b01,
    OP_BOTH = 2'b11
  } chan_op_e;

endpackage

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_pkg::*;
#(
  parameter int unsigned LAT   = 2,
  parameter int unsigned EXTRA = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic enq_i,
  input  logic deq_i,
  output logic push_o,
  output logic pop_o,
  output logic full_o,
  output logic rdy_o,
  output logic preload_o
);
  localparam int unsigned DEPTH = LAT + EXTRA;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned PW    = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pre_q;
  logic          full_q, rdy_q;
  chan_op_e      op;

  // illegal requests are filtered here and never reach the storage
  assign push_o = enq_i & ~full_q;
  assign pop_o  = deq_i & rdy_q;
  assign op     = chan_op_e'({push_o, pop_o});

  always_comb begin
    cnt_d = cnt_q;
    case (op)
      OP_PUSH: cnt_d = cnt_q + 1'b1;
      OP_POP:  cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CW'(LAT);
      full_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == CW'(DEPTH));
      rdy_q  <= (cnt_d != '0);
    end
  end

  // counts the preloaded zero words still ahead of real data
  always_ff @(posedge clk) begin
    if (rst)                         pre_q <= PW'(LAT);
    else if (pop_o && pre_q != '0)   pre_q <= pre_q - 1'b1;
  end

  assign full_o    = full_q;
  assign rdy_o     = rdy_q;
  assign preload_o = (pre_q != '0);
endmodule

// File: rtl/chan_ptr.sv
module chan_ptr
  import chan_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned START = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv_i,
  output logic [idx_bits(DEPTH)-1:0]  ptr_o
);
  localparam int unsigned AW   = idx_bits(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] INIT = AW'(START % DEPTH);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= INIT;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/chan_store.sv
module chan_store
  import chan_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        we_i,
  input  logic [idx_bits(DEPTH)-1:0]  waddr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  input  logic [idx_bits(DEPTH)-1:0]  raddr_i,
  output logic [WIDTH-1:0]            rdata_o
);
  // no reset on the array so it maps to distributed RAM
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tgt_pipe_chan.sv
module tgt_pipe_chan
  import chan_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LAT   = 2,
  parameter int unsigned EXTRA = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_i,
  input  logic [WIDTH-1:0] enq_data_i,
  output logic             full_o,
  output logic             rdy_o,
  input  logic             deq_i,
  output logic [WIDTH-1:0] deq_data_o
);
  localparam int unsigned DEPTH = LAT + EXTRA;
  localparam int unsigned AW    = idx_bits(DEPTH);

  logic          push, pop, preload;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] rd_word;

  chan_ctrl #(.LAT(LAT), .EXTRA(EXTRA)) ctrl_i (
    .clk(clk), .rst(rst), .enq_i(enq_i), .deq_i(deq_i),
    .push_o(push), .pop_o(pop), .full_o(full_o), .rdy_o(rdy_o),
    .preload_o(preload)
  );

  // writes begin behind the LAT virtual zero slots
  chan_ptr #(.DEPTH(DEPTH), .START(LAT)) wptr_i (
    .clk(clk), .rst(rst), .adv_i(push), .ptr_o(wr_ptr)
  );

  chan_ptr #(.DEPTH(DEPTH), .START(0)) rptr_i (
    .clk(clk), .rst(rst), .adv_i(pop), .ptr_o(rd_ptr)
  );

  chan_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we_i(push), .waddr_i(wr_ptr), .wdata_i(enq_data_i),
    .raddr_i(rd_ptr), .rdata_o(rd_word)
  );

  // preloaded slots are never written, so they read as zero here
  assign deq_data_o = preload ? '0 : rd_word;
endmodule

// File: rtl/chan_chk.sv
module chan_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_i,
  input logic             deq_i,
  input logic             full_o,
  input logic             rdy_o,
  input logic [WIDTH-1:0] deq_data_o
);
  a_r1_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdy_o && !full_o));

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (deq_data_o == '0));

  a_r4_flags_consistent: assert property (@(posedge clk) disable iff (rst)
    !(full_o && !rdy_o));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full_o && enq_i && !deq_i) |=> full_o);

  a_r3_full_by_push: assert property (@(posedge clk) disable iff (rst)
    $rose(full_o) |-> $past(enq_i));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && deq_i && !enq_i) |=> !rdy_o);

  a_r7_balanced_steady: assert property (@(posedge clk) disable iff (rst)
    (enq_i && deq_i && rdy_o && !full_o) |=> ($stable(full_o) && $stable(rdy_o)));

  a_r8_head_hold: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && !deq_i) |=> $stable(deq_data_o));
endmodule

bind tgt_pipe_chan chan_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .enq_i(enq_i), .deq_i(deq_i),
  .full_o(full_o), .rdy_o(rdy_o), .deq_data_o(deq_data_o)
);

// File: tb/tgt_pipe_chan_tb.sv
`timescale 1ns/1ps
module tgt_pipe_chan_tb_top;
  localparam int NDUT = 3;
  localparam int QS   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq = 1'b0, deq = 1'b0;
  logic [7:0] din = '0;
  logic [NDUT-1:0] full_w, rdy_w;
  logic [7:0] dat_w [NDUT];

  int total = 0, bad = 0;
  bit done = 0;

  // bench model: queue of words the consumer should see next
  logic [7:0] mq [NDUT][QS];
  int mh [NDUT];
  int mc [NDUT];

  always #2.5 clk = ~clk;

  for (genvar gi = 0; gi < NDUT; gi++) begin : g_dut
    tgt_pipe_chan #(.WIDTH(8), .LAT(1 << gi), .EXTRA(1)) dut_i (
      .clk(clk), .rst(rst), .enq_i(enq), .enq_data_i(din),
      .full_o(full_w[gi]), .rdy_o(rdy_w[gi]), .deq_i(deq),
      .deq_data_o(dat_w[gi])
    );
  end

  function automatic int lat_of(input int i);
    return 1 << i;
  endfunction

  task automatic chk(input bit ok, input string tag, input int dut,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s lat=%0d actual=%0h expected=%0h", tag, lat_of(dut), act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NDUT; i++) begin
      mh[i] = 0;
      mc[i] = lat_of(i);
      for (int s = 0; s < QS; s++) mq[i][s] = '0;
    end
  endtask

  // drive at the falling edge, check outputs, then advance the model at the rising edge
  task automatic step(input bit e, input bit d, input logic [7:0] v, input string tag);
    @(negedge clk);
    enq = e; deq = d; din = v;
    #1;
    for (int i = 0; i < NDUT; i++) begin
      chk(full_w[i] == (mc[i] == lat_of(i) + 1), tag, i, full_w[i], mc[i] == lat_of(i) + 1);
      chk(rdy_w[i] == (mc[i] != 0), tag, i, rdy_w[i], mc[i] != 0);
      if (mc[i] != 0)
        chk(dat_w[i] == mq[i][mh[i]], "R2", i, dat_w[i], mq[i][mh[i]]);
    end
    @(posedge clk);
    for (int i = 0; i < NDUT; i++) begin
      bit ps, pp;
      int tail;
      ps   = e && (mc[i] != lat_of(i) + 1);
      pp   = d && (mc[i] != 0);
      tail = (mh[i] + mc[i]) % QS;
      if (ps) mq[i][tail] = v;
      if (pp) mh[i] = (mh[i] + 1) % QS;
      mc[i] = mc[i] + int'(ps) - int'(pp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enq = 1'b0; deq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // {enq, deq, data}
  localparam logic [9:0] VEC [24] = '{
    {2'b11, 8'h11}, {2'b11, 8'h22}, {2'b10, 8'h33}, {2'b01, 8'h00},
    {2'b11, 8'h44}, {2'b00, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'h55},
    {2'b10, 8'h66}, {2'b10, 8'h77}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'h88}, {2'b11, 8'h99},
    {2'b01, 8'h00}, {2'b10, 8'hAA}, {2'b11, 8'hBB}, {2'b00, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'hCC}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1: flags and zero head right after reset
    for (int i = 0; i < NDUT; i++) begin
      chk(rdy_w[i] == 1'b1, "R1", i, rdy_w[i], 1);
      chk(full_w[i] == 1'b0, "R1", i, full_w[i], 0);
      chk(dat_w[i] == 8'h00, "R1", i, dat_w[i], 0);
    end
    // R1: pop the preloaded zeros while nothing is pushed
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 8'h00, "R1");

    // R7: vector table with balanced and one-sided traffic
    do_reset();
    for (int n = 0; n < 24; n++) step(VEC[n][9], VEC[n][8], VEC[n][7:0], "R7");

    // R3 then R5: one push fills every channel, further pushes are dropped
    do_reset();
    step(1'b1, 1'b0, 8'hA0, "R3");
    #1;
    for (int i = 0; i < NDUT; i++) chk(full_w[i] == 1'b1, "R3", i, full_w[i], 1);
    for (int k = 1; k < 5; k++) step(1'b1, 1'b0, 8'hE0 + k[7:0], "R5");
    // R5: push while full with a same-cycle pop is still dropped
    step(1'b1, 1'b1, 8'hEE, "R5");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 8'h00, "R5");

    // R6: pops on an empty channel are dropped, next push is next out
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 8'h00, "R6");
    #1;
    for (int i = 0; i < NDUT; i++) chk(rdy_w[i] == 1'b0, "R6", i, rdy_w[i], 0);
    step(1'b1, 1'b0, 8'h5A, "R6");
    #1;
    for (int i = 0; i < NDUT; i++) chk(dat_w[i] == 8'h5A, "R6", i, dat_w[i], 8'h5A);

    // R8: head word stays while pushes arrive and no pop happens
    do_reset();
    step(1'b0, 1'b1, 8'h00, "R8");
    step(1'b1, 1'b0, 8'h3C, "R8");
    step(1'b0, 1'b0, 8'h00, "R8");

    // R2 and R4: random stall patterns at several densities on both ends
    do_reset();
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 600; n++) begin
        bit e, d;
        e = ($urandom % 4) < (ph == 0 ? 1 : (ph == 1 ? 3 : 2));
        d = ($urandom % 4) < (ph == 0 ? 3 : (ph == 1 ? 1 : 2));
        step(e, d, 8'($urandom), "R4");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule